// File: doc/BRIEF.md
# Bus-Mapped GPIO Port Controller

This block is a register-mapped general purpose I/O controller for up to 32 pads. The number of pads is a parameter. Software reaches it over a simple APB-style slave with zero-wait 32-bit reads and writes. Every pad has its own configuration word. That word chooses whether the pad's output value reaches the pin, whether its input is visible to software, whether the output buffer drives or floats, and whether and how the pad raises an interrupt.

Software can load the output word directly. It can also change single bits through separate set and clear words, which avoids a read-modify-write. Configuration can be written one pad at a time, to all pads at once, or to a group of eight pads. Pad inputs pass through a two-flop synchronizer. They are then checked against one of five detection modes: high level, low level, rising edge, falling edge and both edges. Detected events latch into a sticky pending word that drives one interrupt line per pad. Software clears pending bits one by one by writing 1 to them.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A write to byte offset 4*i (i < PORTS) stores pwdata[7:0] in pad i's config word. Reading the same offset returns it in bits 7:0 with bits 31:8 zero. Offsets of pads at or above PORTS read 0 and ignore writes. Config fields: bit0 output enable, bit1 input enable, bit2 drive enable, bit3 interrupt enable, bits 7:5 detection mode.
- R2: A write to offset 0x8C stores pwdata[7:0] in the config word of every implemented pad.
- R3: A write to offset 0x90+4*n (n = 0..3) stores pwdata[7:0] in pads 8n to 8n+7 that exist. A group that holds no implemented pad is left without effect.
- R4: Offset 0x88 holds the output word: a write loads it and a read returns it. A write to 0xA4 ORs the data into it, and a write to 0xA0 clears the bits that are 1 in the data. Each write takes effect at the clock edge of the access phase (psel, penable and pwrite all high).
- R5: pad_out[i] equals output bit i ANDed with config bit0. pad_oe[i] equals config bit2, and 0 means high impedance. The input stays readable while the pad floats: config 0x03 floats the pad, 0x07 drives it.
- R6: Bit i of the input word at 0x84 is pad_in[i] after a two-flop synchronizer. A change made before a clock edge is visible after the second rising edge and not after the first. The bit reads 0 while config bit1 is clear.
- R7: The detection mode applies to the synchronized input: 0 high level, 1 low level, 2 rising edge, 3 falling edge, 4 either edge. Codes 5 to 7 detect nothing.
- R8: The pending word at 0x80 is sticky. Writing 1 to bit i clears only bit i, and a single edge sets its bit only once.
- R9: In a level mode, a pending bit that is cleared while the level persists sets again one cycle later. Once the level has gone, it stays clear.
- R10: A pad whose config bit3 is clear never sets a new pending bit.
- R11: irq[i] follows pending bit i. Bits at or above PORTS of the pending, input and output words read 0.
- R12: prdata depends only on paddr and the register state. The write-only and unmapped offsets (0x8C-0xA4 and above 0xA4) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pad_in | input | PORTS | Pad input levels |
| pad_out | output | PORTS | Pad output values |
| pad_oe | output | PORTS | Pad buffer enables (0 = high impedance) |
| irq | output | PORTS | One interrupt line per pad |

## Verification
Random config, output, set and clear writes are mixed in an order fixed by the seed. Each write is checked against a bench model through the readback and the pad pins, which separates a stale write, a wrong write target and bits beyond the pad count. Random pad levels read through the input word test both the input-enable gating and the bit order. Directed sequences drive each detection mode on a pad of its own, with interrupts disabled on one pad and an undefined mode on another. These sequences separate level from edge sensitivity, single-shot from repeated triggering, and per-bit clearing from clearing the whole word. A latency probe shows whether the synchronizer has two stages rather than one.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned CFG_W     = 8;
  localparam int unsigned MAX_PORTS = 32;
  localparam int unsigned WIDX_W    = 6;
  localparam int unsigned GRP_SIZE  = 8;

  // word indices (byte offset / 4)
  localparam int unsigned IDX_PEND = 32;
  localparam int unsigned IDX_IN   = 33;
  localparam int unsigned IDX_OUT  = 34;
  localparam int unsigned IDX_ALL  = 35;
  localparam int unsigned IDX_GRP0 = 36;
  localparam int unsigned IDX_CLR  = 40;
  localparam int unsigned IDX_SET  = 41;

  // detection mode codes, config bits 7:5
  localparam logic [2:0] DET_HIGH = 3'd0;
  localparam logic [2:0] DET_LOW  = 3'd1;
  localparam logic [2:0] DET_RISE = 3'd2;
  localparam logic [2:0] DET_FALL = 3'd3;
  localparam logic [2:0] DET_BOTH = 3'd4;

  typedef struct packed {
    logic [2:0] det;
    logic       spare;
    logic       irq_en;
    logic       drive_en;
    logic       rd_en;
    logic       wr_en;
  } port_cfg_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q, cur_q, prev_q;
  logic [W-1:0] meta_d, cur_d, prev_d;

  always_comb begin
    meta_d = raw;
    cur_d  = meta_q;
    prev_d = cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      cur_q  <= cur_d;
      prev_q <= prev_d;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         set,
  input  logic         clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_d;
  logic         en;

  always_comb begin
    en  = load | set | clr;
    q_d = q_r;
    if (load) q_d = wdata;
    if (set)  q_d = q_r | wdata;
    if (clr)  q_d = q_r & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (en) q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/gpio_port_cell.sv
module gpio_port_cell
  import gpio_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             pend_clr,
  input  logic             smp_cur,
  input  logic             smp_prev,
  output port_cfg_t        cfg,
  output logic             pend
);
  port_cfg_t cfg_q, cfg_d;
  logic      pend_q, pend_d, pend_en;
  logic      hit, ev, level_md;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = port_cfg_t'(cfg_wdata);
  end

  always_comb begin
    case (cfg_q.det)
      DET_HIGH: hit = smp_cur;
      DET_LOW:  hit = ~smp_cur;
      DET_RISE: hit = smp_cur & ~smp_prev;
      DET_FALL: hit = ~smp_cur & smp_prev;
      DET_BOTH: hit = smp_cur ^ smp_prev;
      default:  hit = 1'b0;
    endcase
    level_md = (cfg_q.det == DET_HIGH) || (cfg_q.det == DET_LOW);
    ev       = hit & cfg_q.irq_en;
    pend_d   = pend_q;
    if (pend_clr) pend_d = 1'b0;
    // a clear beats a level (it returns next cycle); an edge survives a clear
    if (ev && !(pend_clr && level_md)) pend_d = 1'b1;
    pend_en  = pend_clr | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign cfg  = cfg_q;
  assign pend = pend_q;
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned PORTS  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [WORD_W-1:0] pwdata,
  output logic [WORD_W-1:0] prdata,
  input  logic [PORTS-1:0]  pad_in,
  output logic [PORTS-1:0]  pad_out,
  output logic [PORTS-1:0]  pad_oe,
  output logic [PORTS-1:0]  irq
);
  localparam int unsigned GROUPS = (PORTS + GRP_SIZE - 1) / GRP_SIZE;

  logic              in_win, wr_hit;
  logic [WIDX_W-1:0] widx;
  logic [PORTS-1:0]  smp_cur, smp_prev;
  logic [PORTS-1:0]  out_q, pend_v, ien_v, rden_v, oen_v, drv_v;
  port_cfg_t         cfg_v [PORTS];
  logic [WORD_W-1:0] rd_word;

  assign in_win = ((paddr >> 8) == '0) && (paddr[1:0] == 2'b00);
  assign widx   = paddr[7:2];
  assign wr_hit = psel & penable & pwrite & in_win;

  gpio_in_sync #(.W(PORTS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (pad_in),
    .cur  (smp_cur),
    .prev (smp_prev)
  );

  gpio_out_reg #(.W(PORTS)) u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .load (wr_hit && (widx == WIDX_W'(IDX_OUT))),
    .set  (wr_hit && (widx == WIDX_W'(IDX_SET))),
    .clr  (wr_hit && (widx == WIDX_W'(IDX_CLR))),
    .wdata(pwdata[PORTS-1:0]),
    .q    (out_q)
  );

  for (genvar i = 0; i < PORTS; i++) begin : g_port
    logic we_i, clr_i;
    assign we_i  = wr_hit && ((widx == WIDX_W'(i)) ||
                              (widx == WIDX_W'(IDX_ALL)) ||
                              (widx == WIDX_W'(IDX_GRP0 + i / GRP_SIZE)));
    assign clr_i = wr_hit && (widx == WIDX_W'(IDX_PEND)) && pwdata[i];

    gpio_port_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (we_i),
      .cfg_wdata(pwdata[CFG_W-1:0]),
      .pend_clr (clr_i),
      .smp_cur  (smp_cur[i]),
      .smp_prev (smp_prev[i]),
      .cfg      (cfg_v[i]),
      .pend     (pend_v[i])
    );

    assign ien_v[i]  = cfg_v[i].irq_en;
    assign rden_v[i] = cfg_v[i].rd_en;
    assign oen_v[i]  = cfg_v[i].wr_en;
    assign drv_v[i]  = cfg_v[i].drive_en;
  end

  always_comb begin
    rd_word = '0;
    if (in_win) begin
      if (widx < WIDX_W'(MAX_PORTS)) begin
        for (int k = 0; k < PORTS; k++) begin
          if (widx == WIDX_W'(k)) rd_word[CFG_W-1:0] = cfg_v[k];
        end
      end else begin
        case (widx)
          WIDX_W'(IDX_PEND): rd_word[PORTS-1:0] = pend_v;
          WIDX_W'(IDX_IN):   rd_word[PORTS-1:0] = smp_cur & rden_v;
          WIDX_W'(IDX_OUT):  rd_word[PORTS-1:0] = out_q;
          default:           rd_word = '0;
        endcase
      end
    end
  end

  assign prdata  = rd_word;
  assign pad_out = out_q & oen_v;
  assign pad_oe  = drv_v;
  assign irq     = pend_v;

  if (GROUPS > 4) begin : g_bad_cfg
    initial $error("PORTS exceeds the four config groups");
  end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned PORTS  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [WORD_W-1:0] pwdata,
  input logic [WORD_W-1:0] prdata,
  input logic [PORTS-1:0]  pad_oe,
  input logic [PORTS-1:0]  out_q,
  input logic [PORTS-1:0]  pend_v,
  input logic [PORTS-1:0]  ien_v
);
  localparam logic [WORD_W-1:0] IMPL = WORD_W'((64'd1 << PORTS) - 64'd1);

  logic wr, wr_set, wr_clr, wr_pend, wr_cfg0, rd_state;
  assign wr       = psel && penable && pwrite;
  assign wr_set   = wr && (paddr == ADDR_W'(4 * IDX_SET));
  assign wr_clr   = wr && (paddr == ADDR_W'(4 * IDX_CLR));
  assign wr_pend  = wr && (paddr == ADDR_W'(4 * IDX_PEND));
  assign wr_cfg0  = wr && (paddr == '0);
  assign rd_state = (paddr == ADDR_W'(4 * IDX_PEND)) || (paddr == ADDR_W'(4 * IDX_IN)) ||
                    (paddr == ADDR_W'(4 * IDX_OUT));

  AST_CFG_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg0 |=> (pad_oe[0] == $past(pwdata[2]))); // R5
  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((out_q & $past(pwdata[PORTS-1:0])) == $past(pwdata[PORTS-1:0]))); // R4
  AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((out_q & $past(pwdata[PORTS-1:0])) == '0)); // R4
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pend |=> ((pend_v & $past(pend_v)) == $past(pend_v))); // R8
  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_v & ~$past(pend_v) & ~$past(ien_v)) == '0)); // R10
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_state |-> ((prdata & ~IMPL) == '0)); // R11
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.PORTS(PORTS), .ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .psel   (psel),
  .penable(penable),
  .pwrite (pwrite),
  .paddr  (paddr),
  .pwdata (pwdata),
  .prdata (prdata),
  .pad_oe (pad_oe),
  .out_q  (out_q),
  .pend_v (pend_v),
  .ien_v  (ien_v)
);

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;
  localparam logic [31:0] IMPL = (32'd1 << NP) - 32'd1;

  logic clk, rst_n, psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic [NP-1:0] pad_in, pad_out, pad_oe, irq;

  gpio_port_ctrl #(.PORTS(NP), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [7:0]  m_cfg [32];
  logic [31:0] m_out;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    int idx = int'(a >> 2);
    if (idx < NP) m_cfg[idx] = d[7:0];
    if (idx == 35) for (int k = 0; k < NP; k++) m_cfg[k] = d[7:0];
    if (idx >= 36 && idx <= 39)
      for (int k = (idx - 36) * 8; k < (idx - 36) * 8 + 8; k++) if (k < NP) m_cfg[k] = d[7:0];
    if (idx == 34) m_out = d & IMPL;
    if (idx == 41) m_out = (m_out | d) & IMPL;
    if (idx == 40) m_out = m_out & ~d;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    model_write(a, d);
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    paddr = a;
    #1;
    d = prdata;
  endtask

  function automatic logic [31:0] oen_mask();
    logic [31:0] m = '0;
    for (int k = 0; k < NP; k++) m[k] = m_cfg[k][0];
    return m;
  endfunction

  function automatic logic [31:0] drv_mask();
    logic [31:0] m = '0;
    for (int k = 0; k < NP; k++) m[k] = m_cfg[k][2];
    return m;
  endfunction

  function automatic logic [31:0] rden_mask();
    logic [31:0] m = '0;
    for (int k = 0; k < NP; k++) m[k] = m_cfg[k][1];
    return m;
  endfunction

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int seed;
    seed = 1234;
    v = $urandom(seed);
    for (int k = 0; k < 32; k++) m_cfg[k] = '0;
    m_out = '0;
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; pad_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    peek(8'h88, v); chk("R4 reset out", v, 0);
    peek(8'h80, v); chk("R8 reset pend", v, 0);
    peek(8'h00, v); chk("R1 reset cfg", v, 0);
    chk("R5 reset oe", 32'(pad_oe), 0);
    chk("R11 reset irq", 32'(irq), 0);

    // R1 R2 R3 R4 R5: random register traffic against the model
    for (int it = 0; it < 300; it++) begin
      int op = int'($urandom_range(0, 9));
      logic [31:0] d = $urandom();
      logic [7:0] a;
      if (op < 4)       a = 8'(4 * $urandom_range(0, 31));
      else if (op == 4) a = 8'h8C;
      else if (op == 5) a = 8'(8'h90 + 4 * $urandom_range(0, 3));
      else if (op == 6) a = 8'h88;
      else if (op == 7) a = 8'hA4;
      else              a = 8'hA0;
      wr(a, d);
      begin
        int pi = int'($urandom_range(0, 31));
        peek(8'(4 * pi), v);
        chk("R1 cfg readback", v, (pi < NP) ? {24'h0, m_cfg[pi]} : 32'h0);
      end
      peek(8'h88, v); chk("R4 out word", v, m_out);
      chk("R5 pad_out", 32'(pad_out), m_out & oen_mask());
      chk("R5 pad_oe", 32'(pad_oe), drv_mask());
      if (it % 10 == 0) begin
        pad_in = NP'($urandom());
        repeat (3) @(negedge clk);
        peek(8'h84, v); chk("R6 input word", v, 32'(pad_in) & rden_mask());
      end
    end

    // R2 broadcast, R3 groups
    wr(8'h8C, 32'h0000_0055);
    peek(8'h00, v); chk("R2 all port0", v, 32'h55);
    peek(8'h5C, v); chk("R2 all port23", v, 32'h55);
    peek(8'h60, v); chk("R2 all port24 absent", v, 0);
    wr(8'h98, 32'h0000_00A3);
    peek(8'h40, v); chk("R3 group2 port16", v, 32'hA3);
    peek(8'h5C, v); chk("R3 group2 port23", v, 32'hA3);
    peek(8'h3C, v); chk("R3 group2 port15 kept", v, 32'h55);
    wr(8'h9C, 32'h0000_00FF);
    peek(8'h7C, v); chk("R3 group3 port31 absent", v, 0);
    peek(8'h5C, v); chk("R3 group3 no effect", v, 32'hA3);

    // R4 R11 upper bits, R12 write-only offsets
    wr(8'hA4, 32'hFFFF_FFFF);
    peek(8'h88, v); chk("R11 out upper zero", v, IMPL);
    wr(8'hA0, 32'h0000_F0F0);
    peek(8'h88, v); chk("R4 clear bits", v, IMPL & ~32'hF0F0);
    peek(8'hA4, v); chk("R12 set word reads 0", v, 0);
    peek(8'h90, v); chk("R12 group word reads 0", v, 0);
    peek(8'hFC, v); chk("R12 unmapped reads 0", v, 0);

    // R5 bidirectional: float while input readable, then drive
    wr(8'h8C, 32'h0);
    wr(8'h88, 32'h0000_0200);
    wr(8'h24, 32'h03);
    pad_in = '0; pad_in[9] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 highz oe", 32'(pad_oe[9]), 0);
    chk("R5 highz out value", 32'(pad_out[9]), 1);
    peek(8'h84, v); chk("R5 input while highz", v, 32'h200);
    wr(8'h24, 32'h07);
    chk("R5 drive oe", 32'(pad_oe[9]), 1);

    // R6 synchronizer latency on port 5
    wr(8'h14, 32'h02);
    pad_in = '0;
    repeat (3) @(negedge clk);
    pad_in[5] = 1'b1;
    @(negedge clk);
    peek(8'h84, v); chk("R6 not after one edge", v & 32'h20, 0);
    @(negedge clk);
    peek(8'h84, v); chk("R6 after two edges", v & 32'h20, 32'h20);

    // interrupts
    wr(8'h8C, 32'h0);
    pad_in = '0;
    repeat (4) @(negedge clk);
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'h04, 32'h0A);  // p1 level high
    wr(8'h08, 32'h2A);  // p2 level low
    wr(8'h0C, 32'h4A);  // p3 rise
    wr(8'h10, 32'h6A);  // p4 fall
    wr(8'h18, 32'h8A);  // p6 both
    wr(8'h1C, 32'h42);  // p7 rise, irq disabled
    wr(8'h20, 32'hAA);  // p8 mode 5
    repeat (3) @(negedge clk);
    wr(8'h80, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    peek(8'h80, v); chk("R9 level low reasserts", v, 32'h4);
    pad_in[1] = 1'b1; pad_in[2] = 1'b1; pad_in[3] = 1'b1; pad_in[4] = 1'b1;
    pad_in[6] = 1'b1; pad_in[7] = 1'b1; pad_in[8] = 1'b1;
    repeat (4) @(negedge clk);
    peek(8'h80, v); chk("R7 R10 modes on rise", v, 32'h4E);
    chk("R11 irq follows pend", 32'(irq), 32'h4E);
    wr(8'h80, 32'h4C);
    repeat (3) @(negedge clk);
    peek(8'h80, v); chk("R8 edge once R9 level holds", v, 32'h02);
    pad_in[1] = 1'b0; pad_in[3] = 1'b0; pad_in[4] = 1'b0; pad_in[6] = 1'b0;
    repeat (4) @(negedge clk);
    peek(8'h80, v); chk("R7 fall and both", v, 32'h52);
    wr(8'h80, 32'h02);
    repeat (3) @(negedge clk);
    peek(8'h80, v); chk("R8 clear one only", v, 32'h50);
    chk("R10 disabled port quiet", 32'(irq[7]), 0);

    finish_run();
  end
endmodule